// File: doc/BRIEF.md
# ADC Window Threshold Suppressor

This block gates a stream of unsigned 14-bit ADC samples that arrive at one sample per clock. A rising edge on the start input opens a window of exactly 64 samples. While the window is captured, the block counts how many samples lie above a threshold. It then applies one of four keep rules. After a fixed 66-clock latency the block emits the window. A window that passes keeps its original samples. A window that fails has each sample replaced by the constant 1000.

The start pulse and the packet marker travel alongside the data with the same delay and keep their shape. A global enable selects between this suppression mode and a plain pass-through with one register of delay. Samples that belong to no window are forwarded unchanged in both modes. The threshold and the rule are taken per channel. They are latched when a window opens, so they may be reprogrammed while a window is in flight.

Top module: `adc_window_gate`

## Requirements
- R1: With the enable low, data, start and marker outputs equal the corresponding inputs one clock earlier.
- R2: With the enable high, data, start and marker leave the block exactly 66 clocks after they enter. Samples outside any window are forwarded unchanged. Reset clears all outputs to 0.
- R3: Rule code 0 keeps every window.
- R4: Rule code 1 keeps a window only if at least one of its samples is over threshold.
- R5: Rule code 2 keeps a window only if at least two of its samples, adjacent or not, are over threshold.
- R6: Rule code 3 keeps a window only if two samples in a row are over threshold.
- R7: Every one of the 64 samples of a rejected window is output as 1000 decimal. The start and marker outputs are unaffected by the decision.
- R8: A window spans exactly 64 samples from the rising edge of start, for any start length from 1 to 64 clocks. The delayed start keeps its original length.
- R9: A rising edge of start inside an open window is ignored. A rising edge on the clock after the 64th sample opens the next window.
- R10: Threshold and rule code are sampled with the first sample of a window. Changes later in that window have no effect on it.
- R11: A sample is over threshold only when it is strictly greater than the threshold, compared as unsigned 14-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | 1 = windowed suppression, 0 = one-clock pass-through |
| data_i | input | 14 | Incoming ADC sample |
| start_i | input | 1 | Window start pulse, 1 to 64 clocks long |
| mark_i | input | 1 | Packet marker |
| thr_i | input | 14 | Threshold for this channel |
| mode_i | input | 2 | Keep rule code: 0 always, 1 one hit, 2 two hits, 3 two consecutive hits |
| data_o | output | 14 | Delayed sample or substitute constant |
| start_o | output | 1 | Delayed start pulse |
| mark_o | output | 1 | Delayed packet marker |

## Verification
Every rule code is run against the same four hit layouts:
- no hit;
- a single hit on the first sample;
- two hits far apart, one of them on the last sample;
- an adjacent pair on the last two samples.

Together these layouts separate each rule from its neighbours. In particular, two separated hits are the only layout that distinguishes rule 2 from rule 3.

Windows are run back to back, with the next rising edge on the clock right after the 64th sample, and with alternating outcomes. This exposes any decision that is applied to the wrong window.

Further windows test specific cases:
- Values equal to the threshold, the maximum code and a zero threshold test the strict unsigned compare.
- A start pulse of full length shows that the window length does not depend on the pulse.
- A second start edge inside a window shows that the edge is ignored.
- A threshold and rule rewritten after the first sample show that the values latched at window start still apply.

// File: rtl/adc_wg_pkg.sv
package adc_wg_pkg;

   // keep-rule encoding as seen on the mode input
   typedef enum logic [1:0] {
      QM_ALWAYS   = 2'd0,
      QM_ONE_HIT  = 2'd1,
      QM_TWO_HITS = 2'd2,
      QM_ADJ_PAIR = 2'd3
   } qual_mode_e;

endpackage

// File: rtl/adc_wg_delay.sv
module adc_wg_delay #(
   parameter int W     = 18,
   parameter int DEPTH = 65
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("adc_wg_delay: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("adc_wg_delay: W must be positive");
   end

   logic [W-1:0] stage_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/adc_wg_qualifier.sv
module adc_wg_qualifier
   import adc_wg_pkg::*;
#(
   parameter int DATA_W  = 14,
   parameter int WIN_LEN = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] sample_i,
   input  logic              start_i,
   input  logic [DATA_W-1:0] thr_i,
   input  qual_mode_e        mode_i,
   output logic              open_o,
   output logic              member_o,
   output logic              keep_o
);

   localparam int CNT_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;

   if (WIN_LEN < 2) begin : g_bad_win
      $error("adc_wg_qualifier: WIN_LEN must be at least 2");
   end

   logic              start_q;
   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [1:0]        hits_q;
   logic              prev_q;
   logic              pair_q;
   logic [DATA_W-1:0] thr_q;
   qual_mode_e        mode_q;
   logic              keep_q;

   logic              open_w, member_w, last_w, hit_w, prev_w, pair_w, pass_w;
   logic [CNT_W-1:0]  idx_w;
   logic [1:0]        hits_base_w, hits_w;
   logic [DATA_W-1:0] thr_w;
   qual_mode_e        mode_w;

   always_comb begin
      open_w      = start_i && !start_q && !busy_q;
      member_w    = open_w || busy_q;
      idx_w       = open_w ? '0 : cnt_q;
      last_w      = member_w && (idx_w == CNT_W'(WIN_LEN - 1));
      thr_w       = open_w ? thr_i  : thr_q;
      mode_w      = open_w ? mode_i : mode_q;
      hit_w       = member_w && (sample_i > thr_w);
      hits_base_w = open_w ? 2'd0 : hits_q;
      hits_w      = (hits_base_w == 2'd2) ? 2'd2 : hits_base_w + {1'b0, hit_w};
      prev_w      = open_w ? 1'b0 : prev_q;
      pair_w      = (open_w ? 1'b0 : pair_q) || (prev_w && hit_w);
      case (mode_w)
         QM_ALWAYS:   pass_w = 1'b1;
         QM_ONE_HIT:  pass_w = (hits_w != 2'd0);
         QM_TWO_HITS: pass_w = (hits_w == 2'd2);
         default:     pass_w = pair_w;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         start_q <= 1'b0;
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         hits_q  <= 2'd0;
         prev_q  <= 1'b0;
         pair_q  <= 1'b0;
         thr_q   <= '0;
         mode_q  <= QM_ALWAYS;
         keep_q  <= 1'b1;
      end else begin
         start_q <= start_i;
         if (member_w) begin
            busy_q <= !last_w;
            cnt_q  <= idx_w + CNT_W'(1);
            hits_q <= hits_w;
            prev_q <= hit_w;
            pair_q <= pair_w;
         end
         if (open_w) begin
            thr_q  <= thr_i;
            mode_q <= mode_i;
         end
         if (last_w) keep_q <= pass_w;
      end
   end

   assign open_o   = open_w;
   assign member_o = member_w;
   assign keep_o   = keep_q;

   // R9: a fresh start edge inside a window only advances the count
   p_retrig_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q && start_i && !start_q |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

   // R10: latched settings hold while a window is open
   p_settings_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |=> $stable(thr_q) && $stable(mode_q));

   // R8: the window closes right after its last sample
   p_window_closes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      last_w |=> !busy_q);

   // R3: rule 0 always ends with a keep decision
   p_always_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      last_w && (mode_w == QM_ALWAYS) |=> keep_q);

endmodule

// File: rtl/adc_window_gate.sv
module adc_window_gate
   import adc_wg_pkg::*;
#(
   parameter int DATA_W     = 14,
   parameter int WIN_LEN    = 64,
   parameter int LATENCY    = 66,
   parameter int FILL_VALUE = 1000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              start_i,
   input  logic              mark_i,
   input  logic [DATA_W-1:0] thr_i,
   input  logic [1:0]        mode_i,
   output logic [DATA_W-1:0] data_o,
   output logic              start_o,
   output logic              mark_o
);

   localparam int PKT_W   = DATA_W + 4;
   localparam int DLY_LEN = LATENCY - 1;
   localparam logic [DATA_W-1:0] FILL = DATA_W'(FILL_VALUE);

   if (LATENCY < WIN_LEN + 2) begin : g_bad_latency
      $error("adc_window_gate: LATENCY must be at least WIN_LEN + 2");
   end
   if (FILL_VALUE < 0 || FILL_VALUE >= (1 << DATA_W)) begin : g_bad_fill
      $error("adc_window_gate: FILL_VALUE does not fit DATA_W");
   end

   logic             q_open, q_member, q_keep;
   logic [PKT_W-1:0] dly_in, dly_out;
   logic [DATA_W-1:0] tail_data;
   logic             tail_start, tail_mark, tail_first, tail_member;
   logic             keep_hold_q, keep_sel;

   adc_wg_qualifier #(
      .DATA_W  (DATA_W),
      .WIN_LEN (WIN_LEN)
   ) u_qual (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (data_i),
      .start_i  (start_i),
      .thr_i    (thr_i),
      .mode_i   (qual_mode_e'(mode_i)),
      .open_o   (q_open),
      .member_o (q_member),
      .keep_o   (q_keep)
   );

   assign dly_in = {data_i, start_i, mark_i, q_open, q_member};

   adc_wg_delay #(
      .W     (PKT_W),
      .DEPTH (DLY_LEN)
   ) u_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (dly_in),
      .q_o    (dly_out)
   );

   assign {tail_data, tail_start, tail_mark, tail_first, tail_member} = dly_out;

   // the first sample of a window carries the fresh decision; later ones reuse it
   assign keep_sel = tail_first ? q_keep : keep_hold_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         data_o      <= '0;
         start_o     <= 1'b0;
         mark_o      <= 1'b0;
         keep_hold_q <= 1'b1;
      end else begin
         keep_hold_q <= keep_sel;
         if (en_i) begin
            data_o  <= (tail_member && !keep_sel) ? FILL : tail_data;
            start_o <= tail_start;
            mark_o  <= tail_mark;
         end else begin
            data_o  <= data_i;
            start_o <= start_i;
            mark_o  <= mark_i;
         end
      end
   end

   // R1: bypass mode is a single register stage
   p_bypass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (data_o == $past(data_i)) && (start_o == $past(start_i))
                && (mark_o == $past(mark_i)));

   // R8: a window head only ever travels with an active start bit
   p_head_has_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tail_first |-> tail_start && tail_member);

   // R2: in suppression mode the start output follows the delay line tail
   p_start_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> start_o == $past(tail_start));

endmodule

// File: tb/adc_window_gate_tb.sv
`timescale 1ns/1ps
module adc_window_gate_tb;

   localparam int DW   = 14;
   localparam int WIN  = 64;
   localparam int LAT  = 66;
   localparam int FILL = 1000;
   localparam int RING = 512;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          en_i;
   logic [DW-1:0] data_i;
   logic          start_i;
   logic          mark_i;
   logic [DW-1:0] thr_i;
   logic [1:0]    mode_i;
   logic [DW-1:0] data_o;
   logic          start_o;
   logic          mark_o;

   always #4 clk = ~clk;

   adc_window_gate u_dut (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .en_i    (en_i),
      .data_i  (data_i),
      .start_i (start_i),
      .mark_i  (mark_i),
      .thr_i   (thr_i),
      .mode_i  (mode_i),
      .data_o  (data_o),
      .start_o (start_o),
      .mark_o  (mark_o)
   );

   int            edges = 0;
   int            checks = 0;
   int            errors = 0;
   bit            done = 0;
   logic [DW-1:0] exp_d  [RING];
   bit            exp_st [RING];
   bit            exp_mk [RING];
   bit            exp_v  [RING];
   string         exp_tag[RING];
   logic [DW-1:0] win [WIN];
   int            cur_thr;
   int            cur_mode;
   string         mode_tag [4] = '{"R3", "R4", "R5", "R6"};

   always @(posedge clk) edges++;

   always @(negedge clk) begin
      if (!done) begin
         int s;
         s = edges % RING;
         if (exp_v[s]) begin
            checks++;
            if (data_o !== exp_d[s] || start_o !== exp_st[s] || mark_o !== exp_mk[s]) begin
               errors++;
               $display("FAIL %s edge %0d: actual d=%0d s=%0b m=%0b expected d=%0d s=%0b m=%0b",
                        exp_tag[s], edges, data_o, start_o, mark_o, exp_d[s], exp_st[s], exp_mk[s]);
            end
            exp_v[s] = 0;
         end
      end
   end

   task automatic drive(input int d, input bit st, input bit mk, input bit en,
                        input int expv, input string tag);
      int slot;
      @(negedge clk);
      data_i  = DW'(d);
      start_i = st;
      mark_i  = mk;
      en_i    = en;
      thr_i   = DW'(cur_thr);
      mode_i  = 2'(cur_mode);
      slot = (edges + (en ? LAT : 1)) % RING;
      exp_d[slot]   = DW'(expv);
      exp_st[slot]  = st;
      exp_mk[slot]  = mk;
      exp_tag[slot] = tag;
      exp_v[slot]   = 1;
   endtask

   // R11: base values never exceed thr; listed positions get thr+1; sample 5 equals thr
   task automatic fill_pattern(input int thr, input int p1, input int p2, input bit all_eq);
      for (int i = 0; i < WIN; i++) begin
         if (all_eq)        win[i] = DW'(thr);
         else if (thr == 0) win[i] = '0;
         else               win[i] = DW'((i * 37 + 11) % (thr + 1));
      end
      if (!all_eq) win[5] = DW'(thr);
      if (p1 >= 0) win[p1] = DW'(thr + 1);
      if (p2 >= 0) win[p2] = DW'(thr + 1);
   endtask

   function automatic bit decide(input int mode, input int thr);
      int  hits = 0;
      bit  adj = 0;
      for (int i = 0; i < WIN; i++) begin
         if (int'(win[i]) > thr) begin
            hits++;
            if (i > 0 && int'(win[i-1]) > thr) adj = 1;
         end
      end
      case (mode)
         0: return 1;
         1: return hits >= 1;
         2: return hits >= 2;
         default: return adj;
      endcase
   endfunction

   task automatic run_window(input int mode, input int thr, input int slen, input int retrig,
                             input bit late, input int gap, input string tag);
      bit keep;
      cur_thr  = thr;
      cur_mode = mode;
      keep = decide(mode, thr);
      for (int i = 0; i < WIN; i++) begin
         if (late && i == 1) begin
            cur_thr  = 0;   // R10: would accept everything if used
            cur_mode = 0;
         end
         drive(int'(win[i]), (i < slen) || (i == retrig), (i % 5) == 2, 1'b1,
               keep ? int'(win[i]) : FILL, tag);
      end
      for (int i = 0; i < gap; i++)
         drive((i * 53 + 3) % 16384, 1'b0, i == 1, 1'b1, (i * 53 + 3) % 16384, "R2");
   endtask

   initial begin
      rst_n = 0; en_i = 0; data_i = '0; start_i = 0; mark_i = 0;
      thr_i = '0; mode_i = '0; cur_thr = 0; cur_mode = 0;
      for (int i = 0; i < RING; i++) exp_v[i] = 0;
      repeat (4) @(negedge clk);
      data_i = 14'd1234; start_i = 1; mark_i = 1;
      @(negedge clk);
      // R2: reset clears the outputs
      checks++;
      if (data_o !== '0 || start_o !== 1'b0 || mark_o !== 1'b0) begin
         errors++;
         $display("FAIL R2 reset: actual d=%0d s=%0b m=%0b expected 0 0 0", data_o, start_o, mark_o);
      end
      start_i = 0; mark_i = 0; data_i = '0;
      rst_n = 1;

      // R1: bypass with start pulses and markers
      cur_thr = 100; cur_mode = 1;
      for (int i = 0; i < 40; i++)
         drive((i * 977 + 5) % 16384, (i % 9) < 3, (i % 4) == 1, 1'b0, (i * 977 + 5) % 16384, "R1");

      for (int i = 0; i < 3; i++)
         drive(0, 1'b0, 1'b0, 1'b1, 0, "R2");

      // R3..R6 with R7/R9: every rule against every hit layout, back to back
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 4; k++) begin
            case (k)
               0: fill_pattern(500, -1, -1, 0);
               1: fill_pattern(500, 0, -1, 0);
               2: fill_pattern(500, 10, 63, 0);
               default: fill_pattern(500, 62, 63, 0);
            endcase
            run_window(m, 500, 1 + k * 20, -1, 0, 0, mode_tag[m]);
         end
         for (int i = 0; i < 3; i++) drive(77 + i, 1'b0, 1'b0, 1'b1, 77 + i, "R2");
      end

      // R11: values equal to a high threshold are not hits; one code above is
      fill_pattern(16382, -1, -1, 1);
      run_window(1, 16382, 3, -1, 0, 0, "R11");
      fill_pattern(16382, -1, -1, 1);
      win[30] = 14'd16383;
      run_window(1, 16382, 3, -1, 0, 0, "R11");
      fill_pattern(0, -1, -1, 0);
      run_window(1, 0, 2, -1, 0, 2, "R11");

      // R8: start held for all 64 samples, rejected window
      fill_pattern(500, -1, -1, 0);
      run_window(2, 500, 64, -1, 0, 2, "R8");
      // R8: a one-clock start still opens a full rejected window
      fill_pattern(500, 20, -1, 0);
      run_window(2, 500, 1, -1, 0, 0, "R8");

      // R9: second edge at sample 40 ignored; next window opens right after
      fill_pattern(500, -1, -1, 0);
      run_window(1, 500, 1, 40, 0, 0, "R9");
      fill_pattern(500, 5, -1, 0);
      run_window(1, 500, 1, -1, 0, 2, "R9");

      // R10: threshold and rule rewritten after the first sample
      fill_pattern(500, -1, -1, 0);
      run_window(1, 500, 2, -1, 1, 2, "R10");
      // R7: rejected then accepted under rule 3, back to back
      fill_pattern(700, 3, 9, 0);
      run_window(3, 700, 5, -1, 0, 0, "R7");
      fill_pattern(700, 30, 31, 0);
      run_window(3, 700, 5, -1, 0, 0, "R7");

      // drain the delay line
      for (int i = 0; i < LAT + 4; i++) drive(i + 9, 1'b0, 1'b0, 1'b1, i + 9, "R2");
      @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL R2 watchdog: actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule